// File: doc/BRIEF.md
# Edge-Triggered Interrupt Input Latch Bank

This block watches five interrupt input pins, catches an edge on each one, and holds it in a per-pin pending latch until software or the interrupt controller clears it. Each pin first passes through a two-flop synchronizer. The synchronized level is XORed with a polarity bit and then fed to a falling-edge detector. Pins 0 to 2 have that polarity bit tied low, so they always trigger on a falling edge. Pins 3 and 4 take their polarity from two software bits.

A pending latch is cleared in two ways. Software can write a 0 to its bit of the data register; the clear is applied once the write strobe ends. The priority controller can also clear it by acknowledging that level. If a new edge arrives in the same cycle as a clear, the edge wins. A 5-bit mask gates the pending latches into the requests sent to the priority controller. The edge pulses of pins 3 and 4 also go out directly to the handshake logic, whatever the mask says.

A mode bit turns the whole bank off for the simple-port mode. In that mode nothing is detected and every latch is held at 0. The status read-back puts the five latches in the low bits and three external status lines in the top bits.

Top module: `irq_edge_bank`

## Requirements
- R1: Pins 0, 1 and 2 set their pending latch (status bits 0..2) only on a high-to-low transition; a low-to-high transition has no effect.
- R2: Pin 3 uses pol_i[0] and pin 4 uses pol_i[1]. A polarity value of 0 selects a falling edge and a value of 1 selects a rising edge.
- R3: The polarity bit is XORed with the pin ahead of the falling-edge detector. Changing polarity from 0 to 1 while the pin is steady high therefore sets that pin's pending latch.
- R4: While port_mode_i is 0 (simple-port mode), no edge is detected, the edge outputs stay 0, and all pending latches read 0, including after port_mode_i returns to 1.
- R5: Writing the data register (wr_stb_i high with wr_data_i) clears every pending latch whose written bit is 0 and leaves the others set. The clear takes effect on the first clock edge after wr_stb_i falls, not while the strobe is still high.
- R6: A 1 on ack_clr_i[n] clears pending latch n at the next clock edge.
- R7: When an edge and a clear (acknowledge or write) hit the same latch in the same cycle, the latch ends up set.
- R8: req_o[n] is 1 only when pending latch n and mask_i[n] are both 1.
- R9: status_o[4:0] holds the pending latches. status_o[5] is irq_n_i, status_o[6] is rd_hs_i and status_o[7] is wr_hs_i.
- R10: Each detected edge on pin 3 or pin 4 produces exactly one single-cycle pulse on edge3_o or edge4_o, regardless of mask_i. The pulse appears in the cycle after the second clock edge following the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_i | input | 5 | Interrupt input pins (asynchronous) |
| pol_i | input | 2 | Edge polarity for pins 3 (bit 0) and 4 (bit 1); 1 selects rising |
| port_mode_i | input | 1 | 1 enables the interrupt bank; 0 is simple-port mode |
| mask_i | input | 5 | Per-pin request enable |
| wr_stb_i | input | 1 | Data register write strobe, level |
| wr_data_i | input | 5 | Write data; a 0 bit clears that latch |
| ack_clr_i | input | 5 | Per-level acknowledge clear |
| irq_n_i | input | 1 | Interrupt output level, reflected in status bit 5 |
| rd_hs_i | input | 1 | Read handshake output, reflected in status bit 6 |
| wr_hs_i | input | 1 | Write handshake output, reflected in status bit 7 |
| req_o | output | 5 | Masked requests to the priority controller |
| edge3_o | output | 1 | Edge pulse from pin 3 |
| edge4_o | output | 1 | Edge pulse from pin 4 |
| status_o | output | 8 | Status register read-back |

## Verification
A pin change made before clock edge k shows up as an edge pulse in the cycle after edge k+1 and in the pending latch after edge k+2. A polarity change feeds the detector at once, so it reaches the latch on the next edge. Write clears land one edge after the strobe falls, and acknowledge clears land on the next edge. The bench drives all inputs just after a falling clock edge and samples just after a later falling edge. Table vectors wait four cycles, beyond the longest of these latencies. The directed tests step exactly one edge at a time, so they can check both the cycle before a result and the cycle it is due, and can line up an acknowledge with the cycle in which the edge pulse is live.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
  parameter int unsigned IRQ_PINS   = 5;
  parameter int unsigned FIXED_PINS = 3;
  parameter int unsigned POL_PINS   = IRQ_PINS - FIXED_PINS;
  parameter int unsigned EXT_STAT   = 3;
  parameter int unsigned STAT_W     = IRQ_PINS + EXT_STAT;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q, stage2_q;
  logic [WIDTH-1:0] stage1_d, stage2_d;

  always_comb begin
    stage1_d = async_i;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned WIDTH     = 5,
  parameter int unsigned FIXED     = 3,
  parameter int unsigned POL_W     = WIDTH - FIXED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [WIDTH-1:0] level_i,
  input  logic [POL_W-1:0] pol_i,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] pol_full;
  logic [WIDTH-1:0] shaped;
  logic [WIDTH-1:0] prev_q, prev_d;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pol
    if (g < FIXED) begin : g_fixed
      assign pol_full[g] = 1'b0;
    end else begin : g_sel
      assign pol_full[g] = pol_i[g-FIXED];
    end
  end

  always_comb begin
    shaped = level_i ^ pol_full;
    prev_d = shaped;
    fall_o = enable_i ? (prev_q & ~shaped) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [WIDTH-1:0] set_i,
  input  logic             wr_stb_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] ack_clr_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] pend_q, pend_d;
  logic [WIDTH-1:0] held_q;
  logic             stb_q;
  logic             wr_end;
  logic [WIDTH-1:0] clr_vec;
  logic             pend_en;
  logic             held_en;

  always_comb begin
    wr_end  = stb_q & ~wr_stb_i;
    clr_vec = ack_clr_i | (wr_end ? ~held_q : '0);
    pend_d  = enable_i ? (set_i | (pend_q & ~clr_vec)) : '0;
    pend_en = enable_i | (|pend_q);
    held_en = wr_stb_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      held_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= wr_stb_i;
      if (held_en) held_q <= wr_data_i;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank
  import irq_edge_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IRQ_PINS-1:0] pin_i,
  input  logic [POL_PINS-1:0] pol_i,
  input  logic                port_mode_i,
  input  logic [IRQ_PINS-1:0] mask_i,
  input  logic                wr_stb_i,
  input  logic [IRQ_PINS-1:0] wr_data_i,
  input  logic [IRQ_PINS-1:0] ack_clr_i,
  input  logic                irq_n_i,
  input  logic                rd_hs_i,
  input  logic                wr_hs_i,
  output logic [IRQ_PINS-1:0] req_o,
  output logic                edge3_o,
  output logic                edge4_o,
  output logic [STAT_W-1:0]   status_o
);
  logic                rst_meta_q, rst_core_n;
  logic [IRQ_PINS-1:0] pin_sync;
  logic [IRQ_PINS-1:0] fall;
  logic [IRQ_PINS-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  irq_pin_sync #(.WIDTH(IRQ_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  irq_edge_det #(.WIDTH(IRQ_PINS), .FIXED(FIXED_PINS), .POL_W(POL_PINS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .enable_i (port_mode_i),
    .level_i  (pin_sync),
    .pol_i    (pol_i),
    .fall_o   (fall)
  );

  irq_pend_bank #(.WIDTH(IRQ_PINS)) u_pend (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .enable_i  (port_mode_i),
    .set_i     (fall),
    .wr_stb_i  (wr_stb_i),
    .wr_data_i (wr_data_i),
    .ack_clr_i (ack_clr_i),
    .pend_o    (pend)
  );

  always_comb begin
    req_o    = pend & mask_i;
    edge3_o  = fall[3];
    edge4_o  = fall[4];
    status_o = {wr_hs_i, rd_hs_i, irq_n_i, pend};
  end
endmodule

// File: rtl/irq_edge_bank_chk.sv
module irq_edge_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_mode_i,
  input logic [4:0] mask_i,
  input logic [4:0] ack_clr_i,
  input logic [4:0] req_o,
  input logic       edge3_o,
  input logic       edge4_o,
  input logic [7:0] status_o
);
  AST_MODE_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !port_mode_i |=> (status_o[4:0] == 5'd0)); // R4
  AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_o & ~mask_i) == 5'd0) && ((req_o & ~status_o[4:0]) == 5'd0)); // R8
  AST_EDGE3_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge3_o |=> !edge3_o); // R10
  AST_EDGE4_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge4_o |=> !edge4_o); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    edge3_o |=> status_o[3]); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr_i[4] && !edge4_o) |=> !status_o[4]); // R6
endmodule

bind irq_edge_bank irq_edge_bank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_mode_i (port_mode_i),
  .mask_i      (mask_i),
  .ack_clr_i   (ack_clr_i),
  .req_o       (req_o),
  .edge3_o     (edge3_o),
  .edge4_o     (edge4_o),
  .status_o    (status_o)
);

// File: tb/irq_edge_bank_tb.sv
module irq_edge_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] pin_i;
  logic [1:0] pol_i;
  logic       port_mode_i;
  logic [4:0] mask_i;
  logic       wr_stb_i;
  logic [4:0] wr_data_i;
  logic [4:0] ack_clr_i;
  logic       irq_n_i, rd_hs_i, wr_hs_i;
  logic [4:0] req_o;
  logic       edge3_o, edge4_o;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_edge_bank u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pol_i(pol_i),
    .port_mode_i(port_mode_i), .mask_i(mask_i), .wr_stb_i(wr_stb_i),
    .wr_data_i(wr_data_i), .ack_clr_i(ack_clr_i), .irq_n_i(irq_n_i),
    .rd_hs_i(rd_hs_i), .wr_hs_i(wr_hs_i), .req_o(req_o),
    .edge3_o(edge3_o), .edge4_o(edge4_o), .status_o(status_o)
  );

  // {pins[4:0], pol[1:0], mask[4:0], pending[4:0], req[4:0]}
  localparam logic [21:0] VEC [8] = '{
    {5'h1F, 2'b00, 5'h1F, 5'h00, 5'h00},  // idle high: nothing pending (R1)
    {5'h1E, 2'b00, 5'h1F, 5'h01, 5'h01},  // pin0 falls (R1)
    {5'h1F, 2'b00, 5'h1F, 5'h01, 5'h01},  // pin0 rises: no effect (R1)
    {5'h1B, 2'b00, 5'h01, 5'h05, 5'h01},  // pin2 falls, masked off (R1, R8)
    {5'h13, 2'b00, 5'h1F, 5'h0D, 5'h0D},  // pin3 falls, polarity 0 (R2)
    {5'h1B, 2'b00, 5'h1F, 5'h0D, 5'h0D},  // pin3 rises, polarity 0 (R2)
    {5'h1B, 2'b10, 5'h1F, 5'h1D, 5'h1D},  // pol4 set with pin4 high (R3)
    {5'h0B, 2'b10, 5'h10, 5'h1D, 5'h10}   // pin4 falls, rising-only (R2, R8)
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt3, cnt4;
    rst_n = 1'b0; pin_i = 5'h1F; pol_i = 2'b00; port_mode_i = 1'b1;
    mask_i = 5'h1F; wr_stb_i = 1'b0; wr_data_i = 5'h00; ack_clr_i = 5'h00;
    irq_n_i = 1'b1; rd_hs_i = 1'b0; wr_hs_i = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(6);
    chk("R9 reset status", status_o, 8'hA0);
    chk("R8 reset req", {3'b0, req_o}, 8'h00);
    chk("R10 reset edges", {6'b0, edge4_o, edge3_o}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      {pin_i, pol_i, mask_i} = VEC[i][21:10];
      step(4);
      chk($sformatf("R1/R2/R3 vec%0d pending", i), {3'b0, status_o[4:0]}, {3'b0, VEC[i][9:5]});
      chk($sformatf("R8 vec%0d req", i), {3'b0, req_o}, {3'b0, VEC[i][4:0]});
    end

    // R9: upper status bits reflect external lines
    irq_n_i = 1'b0; rd_hs_i = 1'b1; wr_hs_i = 1'b0;
    step(1);
    chk("R9 upper bits", {5'b0, status_o[7:5]}, 8'h02);
    irq_n_i = 1'b1; rd_hs_i = 1'b0; wr_hs_i = 1'b1;

    // R5: write clear waits for the strobe to end
    wr_stb_i = 1'b1; wr_data_i = 5'b10110;
    step(1);
    step(1);
    chk("R5 no clear during strobe", {3'b0, status_o[4:0]}, 8'h1D);
    wr_stb_i = 1'b0; wr_data_i = 5'h1F;
    step(1);
    chk("R5 clear after strobe", {3'b0, status_o[4:0]}, 8'h14);

    // R6: acknowledge clear of pin 4
    ack_clr_i = 5'b10000;
    step(1);
    ack_clr_i = 5'h00;
    chk("R6 ack clear", {3'b0, status_o[4:0]}, 8'h04);

    // R7: pin1 edge coincides with acknowledge of pin1
    pin_i = 5'h09;
    step(1);
    step(1);
    ack_clr_i = 5'b00010;
    step(1);
    ack_clr_i = 5'h00;
    chk("R7 set beats ack", {3'b0, status_o[4:0]}, 8'h06);
    ack_clr_i = 5'b00010;
    step(1);
    ack_clr_i = 5'h00;
    chk("R6 ack after set", {3'b0, status_o[4:0]}, 8'h04);

    // R10: pin3 edge pulse, single cycle, mask off, due after two edges
    mask_i = 5'h00;
    cnt3 = 0; cnt4 = 0;
    pin_i = 5'h01;
    step(1);
    chk("R10 no pulse after one edge", {7'b0, edge3_o}, 8'h00);
    for (int k = 0; k < 6; k++) begin
      step(1);
      if (edge3_o) cnt3++;
      if (edge4_o) cnt4++;
    end
    chk("R10 edge3 pulse count", 8'(cnt3), 8'd1);
    chk("R10 edge4 quiet", 8'(cnt4), 8'd0);
    chk("R8 masked req", {3'b0, req_o}, 8'h00);

    // R4: simple-port mode clears and blocks detection
    port_mode_i = 1'b0;
    step(1);
    chk("R4 cleared in mode 0", {3'b0, status_o[4:0]}, 8'h00);
    pin_i = 5'h00;
    cnt3 = 0;
    for (int k = 0; k < 5; k++) begin
      step(1);
      if (edge3_o) cnt3++;
    end
    chk("R4 no edge in mode 0", {3'b0, status_o[4:0]}, 8'h00);
    port_mode_i = 1'b1;
    step(4);
    chk("R4 still clear on return", {3'b0, status_o[4:0]}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule